// File: doc/BRIEF.md
# Idle-Interval Performance Level Governor

This block selects the operating point of a processor core from a small table of performance levels. Each level carries a frequency code for the clock generator and a supply code for the voltage regulator. Both codes are spread linearly between a floor of 59 MHz at 0.8 V and a ceiling of 251 MHz at 1.5 V. The block watches a busy/idle signal from the core. A long enough run of idle cycles moves the core down one level. A long enough run of busy cycles moves it up one level. Software can name a target level directly, and that request takes precedence over the interval policy.

Every change of level follows a fixed sequence. When speed rises, the supply code moves first and the frequency code follows one cycle later. When speed falls, the frequency code moves first. A settle window then stands in for regulator and clock relock time. The core is held stalled from the first code update until the window closes. A one-cycle completion pulse marks the end of the change, and the committed level code updates on that same cycle. A software request that arrives while a change is in progress is held and acted on once the change has finished.

Top module: `dvs_governor`

## Requirements
- R1: Out of reset the level is 0, fcode is 59, vcode is 80, and core_stall and change_done are low.
- R2: fcode holds the frequency in MHz, 59 + floor(192*L/(N_LEVELS-1)). vcode holds the supply in 10 mV units, 80 + floor(70*L/(N_LEVELS-1)). With 8 levels, fcode runs 59,86,113,141,168,196,223,251 and vcode runs 80 to 150 in steps of 10.
- R3: A software request for a level other than the current one starts a change at the next clock edge. core_stall stays high for SETTLE_CYCLES+1 cycles. On the edge that drops the stall, change_done pulses for one cycle and level_code takes the new value.
- R4: When the level rises, vcode takes its new value on the first edge of the change and fcode takes its new value one edge later.
- R5: When the level falls, fcode takes its new value on the first edge of the change and vcode takes its new value one edge later.
- R6: In steady running at a level above 0, the IDLE_CYCLES-th consecutive idle cycle starts a change down by one level. The counting restarts after every change.
- R7: In steady running, the BUSY_CYCLES-th consecutive busy cycle starts a change up by one level. At the top level, busy cycles cause no change.
- R8: At level 0, idle cycles cause no change.
- R9: A request that arrives during a change is held, with the latest one winning. It is serviced on the first edge after change_done.
- R10: A request equal to the current level causes no stall and no change of codes.
- R11: fcode and vcode never change while core_stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_busy | input | 1 | High when the core did useful work this cycle |
| sw_req_valid | input | 1 | One-cycle strobe of a software level request |
| sw_req_level | input | LW | Requested level; values above the top are clamped |
| level_code | output | LW | Committed performance level |
| vcode | output | 8 | Supply code in 10 mV units |
| fcode | output | 8 | Frequency code in MHz |
| core_stall | output | 1 | Holds the core clock-gated during a change |
| change_done | output | 1 | One-cycle pulse when a change completes |

## Verification
A change started by a request driven before edge 1 shows its leading code after edge 1 and its trailing code after edge 2. core_stall is still high after edge SETTLE_CYCLES+1, and change_done with the new level appears after edge SETTLE_CYCLES+2. An interval step shows its stall right after the IDLE_CYCLES-th or BUSY_CYCLES-th edge, counted from the completion pulse. The bench drives inputs and samples outputs on the falling edge and counts rising edges from each stimulus, so every check reads the cycle in which its result becomes due. While requests are being tested, busy alternates every cycle so that no interval step can intrude.

// File: rtl/dvs_gov_pkg.sv
package dvs_gov_pkg;

    localparam int CODE_W     = 8;
    localparam int F_FLOOR    = 59;   // MHz
    localparam int F_CEIL     = 251;  // MHz
    localparam int V_FLOOR    = 80;   // 10 mV units
    localparam int V_CEIL     = 150;  // 10 mV units

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_LEAD   = 2'd1,
        ST_SETTLE = 2'd2
    } gov_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] f;
        logic [CODE_W-1:0] v;
    } op_point_t;

    function automatic int freq_code(input int lvl, input int n);
        if (n < 2) return F_CEIL;
        return F_FLOOR + ((F_CEIL - F_FLOOR) * lvl) / (n - 1);
    endfunction

    function automatic int volt_code(input int lvl, input int n);
        if (n < 2) return V_CEIL;
        return V_FLOOR + ((V_CEIL - V_FLOOR) * lvl) / (n - 1);
    endfunction

endpackage

// File: rtl/dvs_level_table.sv
module dvs_level_table
    import dvs_gov_pkg::*;
#(
    parameter int N_LEVELS = 8,
    localparam int LW = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1
) (
    input  logic [LW-1:0] idx,
    output op_point_t     pt
);
    op_point_t tab [N_LEVELS];

    for (genvar g = 0; g < N_LEVELS; g++) begin : g_entry
        assign tab[g].f = CODE_W'(freq_code(g, N_LEVELS));
        assign tab[g].v = CODE_W'(volt_code(g, N_LEVELS));
    end

    always_comb begin
        if (int'(idx) < N_LEVELS) pt = tab[idx];
        else                      pt = tab[N_LEVELS-1];
    end
endmodule

// File: rtl/dvs_activity_monitor.sv
module dvs_activity_monitor #(
    parameter int IDLE_CYCLES = 16,
    parameter int BUSY_CYCLES = 8,
    localparam int IW = $clog2(IDLE_CYCLES + 1),
    localparam int BW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic clear,
    input  logic core_busy,
    input  logic at_top,
    input  logic at_bottom,
    output logic step_up,
    output logic step_down
);
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYCLES - 1);
    localparam logic [BW-1:0] BUSY_LAST = BW'(BUSY_CYCLES - 1);

    logic [IW-1:0] idle_cnt;
    logic [BW-1:0] busy_cnt;

    assign step_down = enable && !core_busy && (idle_cnt == IDLE_LAST) && !at_bottom;
    assign step_up   = enable &&  core_busy && (busy_cnt == BUSY_LAST) && !at_top;

    always_ff @(posedge clk) begin
        if (rst || !enable || clear) begin
            idle_cnt <= '0;
            busy_cnt <= '0;
        end else if (core_busy) begin
            idle_cnt <= '0;
            if (busy_cnt != BUSY_LAST) busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
            if (idle_cnt != IDLE_LAST) idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dvs_seq_ctrl.sv
module dvs_seq_ctrl
    import dvs_gov_pkg::*;
#(
    parameter int N_LEVELS      = 8,
    parameter int SETTLE_CYCLES = 12,
    localparam int LW = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1,
    localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_req_valid,
    input  logic [LW-1:0]     sw_req_level,
    input  logic              step_up,
    input  logic              step_down,
    input  op_point_t         tab_pt,
    output logic [LW-1:0]     tab_idx,
    output logic              running,
    output logic              start,
    output logic              at_top,
    output logic              at_bottom,
    output logic [LW-1:0]     level,
    output logic [CODE_W-1:0] fcode,
    output logic [CODE_W-1:0] vcode,
    output logic              stall,
    output logic              done
);
    localparam logic [LW-1:0] TOP      = LW'(N_LEVELS - 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYCLES - 1);
    localparam logic [CODE_W-1:0] F_RST = CODE_W'(freq_code(0, N_LEVELS));
    localparam logic [CODE_W-1:0] V_RST = CODE_W'(volt_code(0, N_LEVELS));

    gov_state_e    state;
    logic [LW-1:0] tgt;
    logic          up_dir;
    logic [CW-1:0] cnt;
    logic          pend_v;
    logic [LW-1:0] pend_lvl;
    logic [LW-1:0] req_clamped;
    logic          req_now;
    logic [LW-1:0] req_lvl;
    logic [LW-1:0] nxt;

    assign req_clamped = (sw_req_level > TOP) ? TOP : sw_req_level;
    assign running     = (state == ST_RUN);
    assign at_top      = (level == TOP);
    assign at_bottom   = (level == '0);

    always_comb begin
        req_now = sw_req_valid | pend_v;
        req_lvl = sw_req_valid ? req_clamped : pend_lvl;
        nxt     = level;
        start   = 1'b0;
        if (state == ST_RUN) begin
            if (req_now) begin
                nxt   = req_lvl;
                start = (req_lvl != level);
            end else if (step_down) begin
                nxt   = level - 1'b1;
                start = 1'b1;
            end else if (step_up) begin
                nxt   = level + 1'b1;
                start = 1'b1;
            end
        end
    end

    assign tab_idx = (state == ST_RUN) ? nxt : tgt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            level    <= '0;
            tgt      <= '0;
            up_dir   <= 1'b0;
            fcode    <= F_RST;
            vcode    <= V_RST;
            stall    <= 1'b0;
            done     <= 1'b0;
            cnt      <= '0;
            pend_v   <= 1'b0;
            pend_lvl <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_RUN: begin
                    pend_v <= 1'b0;
                    if (start) begin
                        tgt    <= nxt;
                        up_dir <= (nxt > level);
                        stall  <= 1'b1;
                        state  <= ST_LEAD;
                        if (nxt > level) vcode <= tab_pt.v;
                        else             fcode <= tab_pt.f;
                    end
                end
                ST_LEAD: begin
                    if (up_dir) fcode <= tab_pt.f;
                    else        vcode <= tab_pt.v;
                    cnt   <= '0;
                    state <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (cnt == CNT_LAST) begin
                        state <= ST_RUN;
                        level <= tgt;
                        stall <= 1'b0;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
            if (state != ST_RUN && sw_req_valid) begin
                pend_v   <= 1'b1;
                pend_lvl <= req_clamped;
            end
        end
    end
endmodule

// File: rtl/dvs_governor.sv
module dvs_governor
    import dvs_gov_pkg::*;
#(
    parameter int N_LEVELS      = 8,
    parameter int IDLE_CYCLES   = 16,
    parameter int BUSY_CYCLES   = 8,
    parameter int SETTLE_CYCLES = 12,
    localparam int LW = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_busy,
    input  logic          sw_req_valid,
    input  logic [LW-1:0] sw_req_level,
    output logic [LW-1:0] level_code,
    output logic [7:0]    vcode,
    output logic [7:0]    fcode,
    output logic          core_stall,
    output logic          change_done
);
    op_point_t     tab_pt;
    logic [LW-1:0] tab_idx;
    logic          running;
    logic          start;
    logic          at_top;
    logic          at_bottom;
    logic          step_up;
    logic          step_down;

    dvs_level_table #(.N_LEVELS(N_LEVELS)) u_table (
        .idx (tab_idx),
        .pt  (tab_pt)
    );

    dvs_activity_monitor #(
        .IDLE_CYCLES (IDLE_CYCLES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_monitor (
        .clk       (clk),
        .rst       (rst),
        .enable    (running),
        .clear     (start),
        .core_busy (core_busy),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .step_up   (step_up),
        .step_down (step_down)
    );

    dvs_seq_ctrl #(
        .N_LEVELS      (N_LEVELS),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sw_req_valid (sw_req_valid),
        .sw_req_level (sw_req_level),
        .step_up      (step_up),
        .step_down    (step_down),
        .tab_pt       (tab_pt),
        .tab_idx      (tab_idx),
        .running      (running),
        .start        (start),
        .at_top       (at_top),
        .at_bottom    (at_bottom),
        .level        (level_code),
        .fcode        (fcode),
        .vcode        (vcode),
        .stall        (core_stall),
        .done         (change_done)
    );
endmodule

// File: rtl/dvs_governor_chk.sv
module dvs_governor_chk
    import dvs_gov_pkg::*;
#(
    parameter int N_LEVELS = 8,
    localparam int LW = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic [LW-1:0] level_code,
    input logic [7:0]    vcode,
    input logic [7:0]    fcode,
    input logic          core_stall,
    input logic          change_done
);
    // R11: code movement only while the core is stalled
    p_codes_stalled_r11: assert property (@(posedge clk) disable iff (rst)
        (fcode != $past(fcode) || vcode != $past(vcode)) |-> core_stall);

    // R4: a rising supply code is never joined by a frequency move
    p_volt_leads_r4: assert property (@(posedge clk) disable iff (rst)
        (vcode > $past(vcode)) |-> (fcode == $past(fcode)));

    // R5: a falling frequency code is never joined by a supply move
    p_freq_leads_r5: assert property (@(posedge clk) disable iff (rst)
        (fcode < $past(fcode)) |-> (vcode == $past(vcode)));

    // R3: completion is a single-cycle pulse
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        change_done |=> !change_done);

    // R3: completion coincides with the stall release
    p_done_release_r3: assert property (@(posedge clk) disable iff (rst)
        change_done |-> (!core_stall && $past(core_stall)));

    // R3: the committed level only moves with completion
    p_level_commit_r3: assert property (@(posedge clk) disable iff (rst)
        (level_code != $past(level_code)) |-> change_done);

    // R2: outside a change the codes belong to the committed level
    p_codes_table_r2: assert property (@(posedge clk) disable iff (rst)
        !core_stall |-> (int'(fcode) == freq_code(int'(level_code), N_LEVELS)
                      && int'(vcode) == volt_code(int'(level_code), N_LEVELS)));
endmodule

bind dvs_governor dvs_governor_chk #(.N_LEVELS(N_LEVELS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .level_code  (level_code),
    .vcode       (vcode),
    .fcode       (fcode),
    .core_stall  (core_stall),
    .change_done (change_done)
);

// File: tb/dvs_governor_test.sv
module dvs_governor_test;

    localparam int N_LEVELS = 8;
    localparam int LW       = 3;
    localparam int SETTLE   = 12;
    localparam int IDLE     = 16;
    localparam int BUSY     = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          core_busy = 1'b0;
    logic          sw_req_valid = 1'b0;
    logic [LW-1:0] sw_req_level = '0;
    logic [LW-1:0] level_code;
    logic [7:0]    vcode;
    logic [7:0]    fcode;
    logic          core_stall;
    logic          change_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit toggle_busy = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dvs_governor #(
        .N_LEVELS(N_LEVELS), .IDLE_CYCLES(IDLE),
        .BUSY_CYCLES(BUSY), .SETTLE_CYCLES(SETTLE)
    ) uut (
        .clk(clk), .rst(rst), .core_busy(core_busy),
        .sw_req_valid(sw_req_valid), .sw_req_level(sw_req_level),
        .level_code(level_code), .vcode(vcode), .fcode(fcode),
        .core_stall(core_stall), .change_done(change_done)
    );

    // request level, expected level, expected fcode (MHz), expected vcode (10 mV)
    typedef struct packed {
        logic [3:0] req;
        logic [3:0] lvl;
        logic [7:0] f;
        logic [7:0] v;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'd7, 4'd7, 8'd251, 8'd150},
        '{4'd0, 4'd0, 8'd59,  8'd80},
        '{4'd3, 4'd3, 8'd141, 8'd110},
        '{4'd3, 4'd3, 8'd141, 8'd110},
        '{4'd6, 4'd6, 8'd223, 8'd140},
        '{4'd7, 4'd7, 8'd251, 8'd150}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one rising edge, then return at the following falling edge
    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (toggle_busy) core_busy = ~core_busy;
        end
    endtask

    task automatic request(input int lvl);
        sw_req_valid = 1'b1;
        sw_req_level = LW'(lvl);
        edges(1);
        sw_req_valid = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        int prev;
        int stalls;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 level", level_code, 0);
        chk("R1 fcode", fcode, 59);
        chk("R1 vcode", vcode, 80);
        chk("R1 stall", core_stall, 0);
        chk("R1 done", change_done, 0);

        // R3/R4 raise 0 -> 5 with request timing
        toggle_busy = 1'b1;
        request(5);
        chk("R4 stall at edge 1", core_stall, 1);
        chk("R4 vcode leads", vcode, 130);
        chk("R4 fcode still old", fcode, 59);
        edges(1);
        chk("R4 fcode follows", fcode, 196);
        edges(SETTLE - 1);
        chk("R3 stall last cycle", core_stall, 1);
        chk("R3 no early done", change_done, 0);
        chk("R3 level not yet", level_code, 0);
        edges(1);
        chk("R3 done pulse", change_done, 1);
        chk("R3 stall released", core_stall, 0);
        chk("R3 level committed", level_code, 5);
        edges(1);
        chk("R3 done one cycle", change_done, 0);

        // R2/R3/R10 vector table of requests
        prev = 5;
        foreach (VECS[i]) begin
            request(int'(VECS[i].req));
            chk(int'(VECS[i].req) == prev ? "R10 no stall same level" : "R3 stall starts",
                core_stall, int'(VECS[i].req) != prev);
            edges(15);
            chk("R2 level", level_code, int'(VECS[i].lvl));
            chk("R2 fcode", fcode, int'(VECS[i].f));
            chk("R2 vcode", vcode, int'(VECS[i].v));
            chk("R3 stall idle after", core_stall, 0);
            prev = int'(VECS[i].lvl);
        end

        // R5 lowering order and R9 request held during a change
        request(2);
        chk("R5 fcode leads", fcode, 113);
        chk("R5 vcode still old", vcode, 150);
        edges(1);
        chk("R5 vcode follows", vcode, 100);
        edges(1);
        request(6);                 // arrives at edge 4, inside settle
        edges(10);                  // edge 14
        chk("R9 first change done", change_done, 1);
        chk("R9 first level", level_code, 2);
        edges(1);                   // edge 15
        chk("R9 held request starts", core_stall, 1);
        chk("R9 raise vcode", vcode, 140);
        edges(13);                  // edge 28
        chk("R9 second done", change_done, 1);
        chk("R9 level", level_code, 6);

        // R6 idle interval step down
        toggle_busy = 1'b0;
        core_busy = 1'b0;
        edges(IDLE - 1);
        chk("R6 no step before interval", core_stall, 0);
        edges(1);
        chk("R6 step at interval", core_stall, 1);
        chk("R6 fcode lowered first", fcode, 196);
        chk("R6 vcode unchanged", vcode, 140);
        edges(SETTLE + 1);
        chk("R6 done", change_done, 1);
        chk("R6 level", level_code, 5);

        // R7 busy interval step up
        core_busy = 1'b1;
        edges(BUSY - 1);
        chk("R7 no step before interval", core_stall, 0);
        edges(1);
        chk("R7 step at interval", core_stall, 1);
        chk("R7 vcode raised first", vcode, 140);
        chk("R7 fcode unchanged", fcode, 196);
        edges(SETTLE + 1);
        chk("R7 done", change_done, 1);
        chk("R7 level", level_code, 6);

        // R7 saturation at the top level
        toggle_busy = 1'b1;
        request(7);
        edges(15);
        chk("R7 reached top", level_code, 7);
        toggle_busy = 1'b0;
        core_busy = 1'b1;
        stalls = 0;
        for (int k = 0; k < 40; k++) begin
            edges(1);
            if (core_stall) stalls++;
        end
        chk("R7 top no stall", stalls, 0);
        chk("R7 top level kept", level_code, 7);
        chk("R11 top fcode kept", fcode, 251);

        // R8 saturation at the bottom level
        toggle_busy = 1'b1;
        request(0);
        edges(15);
        chk("R8 reached bottom", level_code, 0);
        toggle_busy = 1'b0;
        core_busy = 1'b0;
        stalls = 0;
        for (int k = 0; k < 40; k++) begin
            edges(1);
            if (core_stall) stalls++;
        end
        chk("R8 bottom no stall", stalls, 0);
        chk("R8 bottom level kept", level_code, 0);
        chk("R11 bottom vcode kept", vcode, 80);

        finished = 1'b1;
        summary();
    end
endmodule